// File: doc/BRIEF.md
# Fixed-Point Add Unit with Condition Record

This block is the integer add lane of a simple in-order core. Each cycle it may accept one decoded 32-bit instruction word together with the two register values already read for it, the current summary-overflow flag, the whole condition register and the address of the instruction. It recognises two add forms: the immediate form, which adds a sign-extended 16-bit constant, and the register-register form, which may also record a classification of the result in the top condition field. One cycle later it presents the destination register index and value, the rewritten condition register when the record bit asks for it, and the address of the following instruction.

Anything that is not one of the two add forms, or is the register form with the overflow-enable bit set, is flagged as illegal. An illegal input writes nothing and does not advance the address. Register storage, fetch and the other add variants sit outside this block.

Top module: `fxadd_unit`

## Requirements
- R1: While reset is asserted, and until the internal synchronised reset is released, out_valid, out_illegal, out_gpr_we and out_cr_we are all 0, whatever the inputs do.
- R2: Each cycle with in_valid=1 gives exactly one cycle with out_valid=1 on the next clock edge. In a cycle after in_valid=0, out_valid, out_illegal, out_gpr_we and out_cr_we are all 0.
- R3: Immediate form: in_insn[31:26]=001110 (14). The 16-bit field in_insn[15:0] is sign-extended and added to the first operand. out_gpr_we=1 and out_cr_we=0.
- R4: In the immediate form, an RA field in_insn[20:16] of 0 selects the constant zero as first operand, and in_src_a has no effect on the result. Any other RA value selects in_src_a.
- R5: Register form: in_insn[31:26]=011111 (31), in_insn[9:1]=100001010 (266) and in_insn[10]=0. The result is in_src_a+in_src_b. This holds even when the RA field is 0. out_gpr_we=1.
- R6: Sums wrap modulo 2^32 and never trap. -3 plus 3 gives 0x00000000, and 0x7FFFFFFF plus 1 gives 0x80000000.
- R7: Record bit. In the register form, out_cr_we equals in_insn[0]. When it is set, out_cr[31:28] is 0x8 if result bit 31 is set, 0x2 if the result is zero and 0x4 otherwise, with in_so ORed into bit 28.
- R8: When the condition register is written, out_cr[27:0] equals in_cr[27:0].
- R9: For a legal instruction, out_nia is in_cia plus 4, modulo the address width.
- R10: Every other encoding raises out_illegal with out_gpr_we=0, out_cr_we=0 and out_nia=in_cia. This covers any other primary opcode, any other extended opcode under 31, and the register form with in_insn[10]=1.
- R11: For a legal instruction, out_gpr_idx is the RT field in_insn[25:21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_insn | input | 32 | Instruction word |
| in_src_a | input | XLEN | Value of the register named by the RA field |
| in_src_b | input | XLEN | Value of the register named by the RB field |
| in_so | input | 1 | Current summary-overflow flag |
| in_cr | input | 32 | Current condition register |
| in_cia | input | ADDR_W | Address of this instruction |
| out_valid | output | 1 | A result is presented |
| out_illegal | output | 1 | The presented instruction was not executed |
| out_gpr_we | output | 1 | Write out_gpr_data to register out_gpr_idx |
| out_gpr_idx | output | 5 | Destination register index |
| out_gpr_data | output | XLEN | Destination value |
| out_cr_we | output | 1 | Write out_cr to the condition register |
| out_cr | output | 32 | New condition register value |
| out_nia | output | ADDR_W | Next instruction address |

## Verification
The bench builds the unit with 32-bit data and addresses, a 4-byte step and a three-stage reset synchroniser in place of the default two. The deeper synchroniser shows that results stay suppressed for every cycle of the longer release, including when instructions are presented during reset. With 32-bit data, the sign bit of the 16-bit immediate and the wrap at 0x7FFFFFFF/0xFFFFFFFF can be hit directly with small constants. A wrap of the address at the top of the space can also be reached by choosing in_cia.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int CR_W      = 32;
  localparam int CRF_W     = 4;
  localparam int IMM_W     = 16;

  localparam logic [5:0] PRI_ADD_IMM = 6'd14;
  localparam logic [5:0] PRI_XFORM   = 6'd31;
  localparam logic [8:0] XO_ADD      = 9'd266;

  typedef enum logic [1:0] {
    KIND_BAD = 2'd0,
    KIND_IMM = 2'd1,
    KIND_REG = 2'd2
  } add_kind_e;

  typedef struct packed {
    add_kind_e              kind;
    logic [REG_IDX_W-1:0]   rt;
    logic                   zero_a;
    logic                   record;
    logic [IMM_W-1:0]       imm;
  } add_dec_t;
endpackage

// File: rtl/fxadd_decode.sv
module fxadd_decode
  import fxadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output add_dec_t          dec
);
  // Fields use big-endian bit numbering: bit 0 of the word is insn[31].
  logic [5:0] primary;
  logic [8:0] ext_op;
  logic       oe_bit;
  logic       rc_bit;
  logic [4:0] ra_fld;

  always_comb begin
    primary = insn[31:26];
    ra_fld  = insn[20:16];
    oe_bit  = insn[10];
    ext_op  = insn[9:1];
    rc_bit  = insn[0];

    dec.kind   = KIND_BAD;
    dec.rt     = insn[25:21];
    dec.imm    = insn[15:0];
    dec.zero_a = 1'b0;
    dec.record = 1'b0;

    if (primary == PRI_ADD_IMM) begin
      dec.kind   = KIND_IMM;
      dec.zero_a = (ra_fld == '0);
    end else if (primary == PRI_XFORM && ext_op == XO_ADD && !oe_bit) begin
      dec.kind   = KIND_REG;
      dec.record = rc_bit;
    end
  end
endmodule

// File: rtl/fxadd_sum.sv
module fxadd_sum
  import fxadd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  add_dec_t        dec,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] sum
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] opnd_a;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
    opnd_a  = dec.zero_a ? '0 : src_a;
    opnd_b  = (dec.kind == KIND_IMM) ? imm_ext : src_b;
    sum     = opnd_a + opnd_b;
  end
endmodule

// File: rtl/fxadd_crf.sv
module fxadd_crf
  import fxadd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]       sum,
  input  logic                  so,
  input  logic [CR_W-CRF_W-1:0] cr_keep,
  output logic [CR_W-1:0]       cr_new
);
  logic [CRF_W-1:0] field;

  always_comb begin
    if (sum[XLEN-1])      field = 4'b1000;
    else if (sum == '0)   field = 4'b0010;
    else                  field = 4'b0100;
    field[0] = so;
    cr_new   = {field, cr_keep};
  end
endmodule

// File: rtl/fxadd_unit.sv
module fxadd_unit
  import fxadd_pkg::*;
#(
  parameter int XLEN            = 32,
  parameter int ADDR_W          = 32,
  parameter int INSN_BYTES      = 4,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    in_insn,
  input  logic [XLEN-1:0]      in_src_a,
  input  logic [XLEN-1:0]      in_src_b,
  input  logic                 in_so,
  input  logic [CR_W-1:0]      in_cr,
  input  logic [ADDR_W-1:0]    in_cia,
  output logic                 out_valid,
  output logic                 out_illegal,
  output logic                 out_gpr_we,
  output logic [REG_IDX_W-1:0] out_gpr_idx,
  output logic [XLEN-1:0]      out_gpr_data,
  output logic                 out_cr_we,
  output logic [CR_W-1:0]      out_cr,
  output logic [ADDR_W-1:0]    out_nia
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
  localparam int KEEP_W = CR_W - CRF_W;

  // Reset: asserted at once, released after RST_SYNC_STAGES edges.
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_SYNC_STAGES-1];

  // Datapath
  add_dec_t         dec;
  logic [XLEN-1:0]  sum;
  logic [CR_W-1:0]  cr_calc;

  fxadd_decode u_decode (
    .insn (in_insn),
    .dec  (dec)
  );

  fxadd_sum #(.XLEN(XLEN)) u_sum (
    .dec   (dec),
    .src_a (in_src_a),
    .src_b (in_src_b),
    .sum   (sum)
  );

  fxadd_crf #(.XLEN(XLEN)) u_crf (
    .sum     (sum),
    .so      (in_so),
    .cr_keep (in_cr[KEEP_W-1:0]),
    .cr_new  (cr_calc)
  );

  // Next state
  logic                 nxt_valid, nxt_illegal, nxt_gpr_we, nxt_cr_we;
  logic [ADDR_W-1:0]    nxt_nia;
  logic                 payload_en;
  logic                 is_legal;

  always_comb begin
    is_legal    = (dec.kind != KIND_BAD);
    nxt_valid   = in_valid;
    nxt_illegal = in_valid && !is_legal;
    nxt_gpr_we  = in_valid && is_legal;
    nxt_cr_we   = in_valid && (dec.kind == KIND_REG) && dec.record;
    nxt_nia     = is_legal ? (in_cia + STEP) : in_cia;
    payload_en  = in_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid    <= 1'b0;
      out_illegal  <= 1'b0;
      out_gpr_we   <= 1'b0;
      out_cr_we    <= 1'b0;
      out_gpr_idx  <= '0;
      out_gpr_data <= '0;
      out_cr       <= '0;
      out_nia      <= '0;
    end else begin
      out_valid   <= nxt_valid;
      out_illegal <= nxt_illegal;
      out_gpr_we  <= nxt_gpr_we;
      out_cr_we   <= nxt_cr_we;
      if (payload_en) begin
        out_gpr_idx  <= dec.rt;
        out_gpr_data <= sum;
        out_cr       <= cr_calc;
        out_nia      <= nxt_nia;
      end
    end
  end

  // Assertions
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !(out_valid || out_gpr_we || out_cr_we || out_illegal));
  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_illegal |-> !(out_gpr_we || out_cr_we));
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_insn[31:26] != PRI_ADD_IMM && in_insn[31:26] != PRI_XFORM)
      |=> (out_illegal && out_nia == $past(in_cia)));
  a_r7_cr_needs_gpr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_cr_we |-> out_gpr_we);
  a_r7_sign_class: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_cr_we |-> (out_cr[CR_W-1] == out_gpr_data[XLEN-1]) &&
                  (out_cr[CR_W-3] == (out_gpr_data == '0)) &&
                  ($countones(out_cr[CR_W-1:CR_W-3]) == 1));
  a_r7_so_copy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_cr_we |-> out_cr[CR_W-4] == $past(in_so));
  a_r8_keep_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_cr_we |-> out_cr[KEEP_W-1:0] == $past(in_cr[KEEP_W-1:0]));
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_illegal) |-> out_nia == $past(in_cia) + STEP);
  a_r11_rt_index: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_gpr_we |-> out_gpr_idx == $past(in_insn[25:21]));
endmodule

// File: tb/test_fxadd_unit.sv
module test_fxadd_unit;
  localparam int XLEN = 32;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     in_insn;
  logic [XLEN-1:0] in_src_a, in_src_b;
  logic            in_so;
  logic [31:0]     in_cr;
  logic [AW-1:0]   in_cia;
  logic            out_valid, out_illegal, out_gpr_we, out_cr_we;
  logic [4:0]      out_gpr_idx;
  logic [XLEN-1:0] out_gpr_data;
  logic [31:0]     out_cr;
  logic [AW-1:0]   out_nia;

  always #10 clk = ~clk;  // 50 MHz

  fxadd_unit #(.XLEN(XLEN), .ADDR_W(AW), .INSN_BYTES(4), .RST_SYNC_STAGES(3)) i_fxadd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_so(in_so), .in_cr(in_cr),
    .in_cia(in_cia), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_gpr_we(out_gpr_we), .out_gpr_idx(out_gpr_idx), .out_gpr_data(out_gpr_data),
    .out_cr_we(out_cr_we), .out_cr(out_cr), .out_nia(out_nia)
  );

  typedef struct packed {
    logic        ill;
    logic        gwe;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        cwe;
    logic [31:0] cr;
    logic [31:0] nia;
    logic [31:0] cyc;
    logic [7:0]  tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc    = 0;
  bit          mon_on = 1'b0;
  bit          done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_imm(int rt, int ra, logic [15:0] imm);
    return {6'd14, 5'(rt), 5'(ra), imm};
  endfunction

  function automatic logic [31:0] enc_reg(int rt, int ra, int rb, bit oe, bit rc);
    return {6'd31, 5'(rt), 5'(ra), 5'(rb), oe, 9'd266, rc};
  endfunction

  // Reference model written from the requirements.
  function automatic exp_t model(logic [31:0] w, logic [31:0] a, logic [31:0] b,
                                 logic so, logic [31:0] cr, logic [31:0] cia);
    exp_t        e;
    logic [31:0] res;
    logic [3:0]  f;
    e = '0;
    e.idx = w[25:21];
    res = '0;
    if (w[31:26] == 6'd14) begin                       // R3, R4
      res   = ((w[20:16] == 0) ? 32'h0 : a) + {{16{w[15]}}, w[15:0]};
      e.gwe = 1'b1;
    end else if (w[31:26] == 6'd31 && w[9:1] == 9'd266 && !w[10]) begin  // R5
      res   = a + b;
      e.gwe = 1'b1;
      e.cwe = w[0];                                    // R7
    end else begin
      e.ill = 1'b1;                                    // R10
    end
    f = res[31] ? 4'h8 : (res == 0) ? 4'h2 : 4'h4;
    f[0] = so;
    e.data = res;
    e.cr   = {f, cr[27:0]};
    e.nia  = e.ill ? cia : cia + 32'd4;                // R9
    return e;
  endfunction

  task automatic issue(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic so,
                       logic [31:0] cr, logic [31:0] cia, int tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; in_src_a = a; in_src_b = b;
    in_so = so; in_cr = cr; in_cia = cia;
    e     = model(w, a, b, so, cr, cia);
    e.cyc = cyc + 1;
    e.tag = 8'(tag);
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pop expected items as results appear.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check("R2 spurious out_valid", 32'(out_valid), 32'd0);
        end else begin
          exp_t e;
          string dtag;
          e = sb.pop_front();
          dtag = $sformatf("R%0d data", e.tag);
          check("R2 latency cycle", 32'(cyc), e.cyc);
          check("R10 illegal flag", 32'(out_illegal), 32'(e.ill));
          check("R10 gpr_we", 32'(out_gpr_we), 32'(e.gwe));
          check("R7 cr_we", 32'(out_cr_we), 32'(e.cwe));
          check("R9 next address", out_nia, e.nia);
          if (e.gwe) begin
            check("R11 dest index", 32'(out_gpr_idx), 32'(e.idx));
            check(dtag, out_gpr_data, e.data);
          end
          if (e.cwe) check("R7 R8 cr value", out_cr, e.cr);
        end
      end else begin
        check("R2 idle quiet", 32'({out_gpr_we, out_cr_we, out_illegal}), 32'd0);
      end
    end
  end

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_insn = '0; in_src_a = '0; in_src_b = '0;
    in_so = 1'b0; in_cr = '0; in_cia = '0;

    // R1: inputs active during reset produce nothing
    @(negedge clk);
    in_valid = 1'b1; in_insn = enc_imm(3, 0, 16'd5);
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", 32'(out_valid), 0);
    check("R1 out_gpr_we in reset", 32'(out_gpr_we), 0);
    check("R1 out_cr_we in reset", 32'(out_cr_we), 0);
    check("R1 out_illegal in reset", 32'(out_illegal), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out_valid during sync release", 32'(out_valid), 0);
    repeat (4) @(negedge clk);
    check("R1 out_valid after release", 32'(out_valid), 0);
    mon_on = 1'b1;

    // R3: immediate form, positive and negative constants, back to back
    issue(enc_imm(3, 3, 16'd1), 32'd0, 32'hDEAD, 0, 32'h0, 32'h0012_0000, 3);
    issue(enc_imm(3, 3, 16'd1), 32'd1, 32'hDEAD, 0, 32'h0, 32'h0012_0004, 3);
    issue(enc_imm(4, 7, 16'hFFFD), 32'd100, 32'h0, 0, 32'h0, 32'h0012_0008, 3);
    idle(2);
    // R4: RA field zero ignores in_src_a
    issue(enc_imm(6, 0, 16'd10), 32'h1234_5678, 32'h0, 0, 32'h0, 32'h100, 4);
    issue(enc_imm(7, 0, 16'hFFFB), 32'hFFFF_FFFF, 32'h0, 1, 32'h0, 32'h104, 4);
    // R5: register form, RA field 0 still reads in_src_a
    issue(enc_reg(9, 0, 2, 0, 0), 32'd40, 32'd2, 0, 32'h0ABC_DEF5, 32'h108, 5);
    issue(enc_reg(31, 12, 13, 0, 0), 32'h0001_0000, 32'h0000_FFFF, 0, 32'h0, 32'h10C, 5);
    idle(1);
    // R6 + R7 + R8: wrap to zero with record, low CR bits preserved
    issue(enc_reg(4, 4, 3, 0, 1), 32'hFFFF_FFFD, 32'd3, 0, 32'h0ABC_DEF5, 32'h200, 6);
    issue(enc_reg(4, 4, 3, 0, 1), 32'hFFFF_FFFD, 32'd3, 1, 32'hF555_5555, 32'h204, 6);
    issue(enc_reg(5, 1, 2, 0, 1), 32'h7FFF_FFFF, 32'd1, 0, 32'h1234_5678, 32'h208, 6);
    issue(enc_reg(8, 1, 2, 0, 1), 32'd7, 32'd8, 1, 32'hFFFF_FFFF, 32'h20C, 7);
    issue(enc_reg(8, 1, 2, 0, 1), 32'd7, 32'd8, 0, 32'h0000_0000, 32'h210, 7);
    issue(enc_imm(2, 1, 16'h8000), 32'h8000_0000, 32'h0, 1, 32'h0, 32'h214, 6);
    idle(2);
    // R9: address wraps at the top of the space
    issue(enc_imm(1, 1, 16'd1), 32'd1, 32'h0, 0, 32'h0, 32'hFFFF_FFFC, 9);
    // R10: other primary opcode, overflow-enable form, other extended opcode
    issue(32'h0000_0000, 32'd1, 32'd2, 0, 32'h0, 32'h300, 10);
    issue(enc_reg(4, 1, 2, 1, 1), 32'd1, 32'd2, 0, 32'h0, 32'h304, 10);
    issue({6'd31, 5'd4, 5'd1, 5'd2, 1'b0, 9'd491, 1'b1}, 32'd10, 32'd5, 0, 32'h0, 32'h308, 10);
    issue({6'd15, 5'd4, 5'd0, 16'd1}, 32'd10, 32'd5, 0, 32'h0, 32'h30C, 10);
    // R11: legal after illegal, distinct destination
    issue(enc_reg(17, 1, 2, 0, 0), 32'd10, 32'd5, 0, 32'h0, 32'h310, 11);
    idle(4);

    // R2: every issued item was answered
    check("R2 all results delivered", 32'(sb.size()), 0);
    done = 1'b1;
    report();
  end
endmodule